// File: doc/BRIEF.md
# Flash Page Buffer Address Mapper

This block turns a host byte offset within one flash page into an address in the controller's internal page buffer RAM. Main-area bytes map one to one onto the buffer, starting at address zero. Spare-area bytes do not form a single run. Each 512-byte sector of the page owns a separate 64-byte spare window above address 0x1000. Within each window, only an even-rounded share of the spare bytes is used, and the last window in use takes the leftover bytes.

The host presents a column, a page-size select, the spare size and a spare-only flag, then pulses `reqValid`. One cycle later the block returns the buffer address and a run length. The run length is the number of bytes that stay contiguous from that address before a window or region edge. A burst engine moves at most that many bytes, then asks again with the advanced column. This is also how a transfer that starts in the main area continues into the spare area.

Top module: `spare_addr_mapper`

## Requirements
- R1: While `rstN` is low, and after its release until the first request, `respValid`, `bufAddr`, `runLen` and `inSpare` are all zero.
- R2: A request sampled at a rising edge with `reqValid` high gives its result and `respValid` high right after that edge. `respValid` is low after any edge where `reqValid` was low, and all result outputs then keep their previous values.
- R3: `pageSel` encodes the page size: 0 means 512 bytes, 1 means 2048 bytes, and 2 or 3 mean 4096 bytes. A column below the page size with `spareOnly` low gives `bufAddr` equal to the column, `runLen` equal to the page size minus the column, and `inSpare` low.
- R4: A column at or above the page size, with `spareOnly` low, selects the spare area at offset column minus page size, and `inSpare` goes high. A column equal to the page size therefore maps to 0x1000, which is spare offset 0.
- R5: With `spareOnly` high, the column is used directly as the spare offset, and `inSpare` is high.
- R6: The number of windows in use is the page size divided by 512. Each window holds the spare size divided by that count, rounded down to an even number. The window index is the spare offset divided by that share, and the address is 0x1000 + index*0x40 + (offset - index*share).
- R7: The index is capped at the last window in use. That window takes every remaining byte, and there `runLen` equals the spare size minus the offset.
- R8: In a window other than the last in use, `runLen` equals the share minus the offset within the window.
- R9: A spare offset at or beyond the spare size gives `runLen` of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | Request strobe, samples the other inputs |
| column | input | 13 | Byte offset in the page, or spare offset in spare-only mode |
| pageSel | input | 2 | Page size: 0 = 512, 1 = 2048, 2 or 3 = 4096 |
| spareSize | input | 8 | Spare bytes per page |
| spareOnly | input | 1 | Treat the column as a spare offset |
| respValid | output | 1 | Result valid, one cycle after the request |
| bufAddr | output | 13 | Buffer RAM address |
| runLen | output | 13 | Contiguous bytes left from `bufAddr` |
| inSpare | output | 1 | Result lies in the spare area |

## Verification
The window-index cap and the remainder rule can act on the same offset. In the last window, the cap decides the index and the remainder rule decides the run length. Offsets just below, at and beyond the even-split edge of the 4096/218 geometry provoke this case. Each result is compared with an address and run length computed by hand from the requirements. The main/spare boundary and spare-only mode are checked at the same column values, so that the region decision is judged apart from the window split.

// File: rtl/nand_map_pkg.sv
package nand_map_pkg;
  // strobes from the control half to the datapath half
  typedef struct packed {
    logic       load;        // capture a new mapping
    logic       spareSel;    // result lies in the spare area
    logic       useColumn;   // column is already a spare offset
    logic [1:0] chunkShift;  // log2 of sectors per page
  } mapCtrl_t;
endpackage

// File: rtl/map_ctrl.sv
module map_ctrl
  import nand_map_pkg::*;
#(
  parameter int COL_W  = 13,
  parameter int SECTOR = 512
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [COL_W-1:0] column,
  input  logic [1:0]       pageSel,
  input  logic             spareOnly,
  output mapCtrl_t         ctrl,
  output logic [COL_W-1:0] pageBytes,
  output logic             respValid
);
  logic [1:0] shiftSel;

  always_comb begin
    case (pageSel)
      2'd0:    shiftSel = 2'd0;
      2'd1:    shiftSel = 2'd2;
      default: shiftSel = 2'd3;
    endcase
  end

  assign pageBytes      = COL_W'(SECTOR) << shiftSel;
  assign ctrl.load      = reqValid;
  assign ctrl.useColumn = spareOnly;
  assign ctrl.spareSel  = spareOnly || (column >= pageBytes);
  assign ctrl.chunkShift = shiftSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) respValid <= 1'b0;
    else       respValid <= reqValid;
  end
endmodule

// File: rtl/map_datapath.sv
module map_datapath
  import nand_map_pkg::*;
#(
  parameter int                COL_W      = 13,
  parameter int                SPARE_W    = 8,
  parameter int                ADDR_W     = 13,
  parameter int                NUM_BUF    = 8,
  parameter int                STRIDE     = 64,
  parameter logic [ADDR_W-1:0] SPARE_BASE = 13'h1000
) (
  input  logic               clk,
  input  logic               rstN,
  input  mapCtrl_t           ctrl,
  input  logic [COL_W-1:0]   column,
  input  logic [COL_W-1:0]   pageBytes,
  input  logic [SPARE_W-1:0] spareSize,
  output logic [ADDR_W-1:0]  bufAddr,
  output logic [COL_W-1:0]   runLen,
  output logic               inSpare
);
  localparam int IDX_W = $clog2(NUM_BUF);
  localparam int OFF_W = $clog2(STRIDE);

  logic [COL_W-1:0]   offs, share, spareW, base, inner, spareLen, mainLen;
  logic [SPARE_W-1:0] shareNarrow;
  logic [IDX_W:0]     chunks;
  logic [IDX_W-1:0]   lastIdx, idx;
  logic [NUM_BUF-1:1] geK;
  logic [ADDR_W-1:0]  spareAddr;

  assign offs        = ctrl.useColumn ? column : column - pageBytes;
  assign shareNarrow = (spareSize >> ctrl.chunkShift) & ~SPARE_W'(1);
  assign share       = COL_W'(shareNarrow);
  assign spareW      = COL_W'(spareSize);
  assign chunks      = (IDX_W+1)'(1) << ctrl.chunkShift;
  assign lastIdx     = IDX_W'(chunks - 1'b1);

  // one threshold compare per window edge; only edges below the last used window count
  for (genvar k = 1; k < NUM_BUF; k++) begin : g_edge
    assign geK[k] = (IDX_W'(k) <= lastIdx) && (offs >= COL_W'(k) * share);
  end

  always_comb begin
    idx = '0;
    for (int k = 1; k < NUM_BUF; k++) idx = idx + IDX_W'(geK[k]);
  end

  assign base      = COL_W'(idx) * share;
  assign inner     = offs - base;
  assign spareAddr = SPARE_BASE + ADDR_W'(idx) * ADDR_W'(STRIDE) + ADDR_W'(inner[OFF_W-1:0]);
  assign mainLen   = pageBytes - column;

  always_comb begin
    if (idx != lastIdx)      spareLen = share - inner;
    else if (offs < spareW)  spareLen = spareW - offs;
    else                     spareLen = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufAddr <= '0;
      runLen  <= '0;
      inSpare <= 1'b0;
    end else if (ctrl.load) begin
      bufAddr <= ctrl.spareSel ? spareAddr : ADDR_W'(column);
      runLen  <= ctrl.spareSel ? spareLen : mainLen;
      inSpare <= ctrl.spareSel;
    end
  end
endmodule

// File: rtl/spare_addr_mapper.sv
module spare_addr_mapper
  import nand_map_pkg::*;
#(
  parameter int COL_W   = 13,
  parameter int SPARE_W = 8,
  parameter int ADDR_W  = 13
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [COL_W-1:0]   column,
  input  logic [1:0]         pageSel,
  input  logic [SPARE_W-1:0] spareSize,
  input  logic               spareOnly,
  output logic               respValid,
  output logic [ADDR_W-1:0]  bufAddr,
  output logic [COL_W-1:0]   runLen,
  output logic               inSpare
);
  mapCtrl_t         ctrl;
  logic [COL_W-1:0] pageBytes;

  map_ctrl #(.COL_W(COL_W), .SECTOR(512)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .column(column),
    .pageSel(pageSel), .spareOnly(spareOnly), .ctrl(ctrl),
    .pageBytes(pageBytes), .respValid(respValid)
  );

  map_datapath #(.COL_W(COL_W), .SPARE_W(SPARE_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .column(column),
    .pageBytes(pageBytes), .spareSize(spareSize),
    .bufAddr(bufAddr), .runLen(runLen), .inSpare(inSpare)
  );
endmodule

// File: rtl/spare_addr_mapper_chk.sv
module spare_addr_mapper_chk #(
  parameter int COL_W   = 13,
  parameter int SPARE_W = 8,
  parameter int ADDR_W  = 13
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic               spareOnly,
  input logic [SPARE_W-1:0] spareSize,
  input logic               respValid,
  input logic [ADDR_W-1:0]  bufAddr,
  input logic [COL_W-1:0]   runLen,
  input logic               inSpare
);
  localparam logic [ADDR_W-1:0] SPARE_LO = ADDR_W'(13'h1000);
  localparam logic [ADDR_W-1:0] SPARE_HI = ADDR_W'(13'h1200);

  AST_RESP_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!respValid && $stable(bufAddr) && $stable(runLen) && $stable(inSpare))); // R2
  AST_MAIN_BELOW_SPARE: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !inSpare) |-> (bufAddr < SPARE_LO && runLen != '0)); // R3
  AST_SPARE_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && inSpare) |-> (bufAddr >= SPARE_LO && bufAddr < SPARE_HI)); // R6
  AST_SPARE_ONLY_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && $past(spareOnly)) |-> inSpare); // R5
  AST_SPARE_LEN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && inSpare) |-> (runLen <= COL_W'($past(spareSize)))); // R7
endmodule

bind spare_addr_mapper spare_addr_mapper_chk #(
  .COL_W(COL_W), .SPARE_W(SPARE_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .spareOnly(spareOnly),
  .spareSize(spareSize), .respValid(respValid), .bufAddr(bufAddr),
  .runLen(runLen), .inSpare(inSpare)
);

// File: tb/tb_spare_addr_mapper.sv
module tb_spare_addr_mapper;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [12:0] column = '0;
  logic [1:0]  pageSel = '0;
  logic [7:0]  spareSize = '0;
  logic        spareOnly = 1'b0;
  logic        respValid;
  logic [12:0] bufAddr;
  logic [12:0] runLen;
  logic        inSpare;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  spare_addr_mapper dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .column(column),
    .pageSel(pageSel), .spareSize(spareSize), .spareOnly(spareOnly),
    .respValid(respValid), .bufAddr(bufAddr), .runLen(runLen), .inSpare(inSpare)
  );

  // {pageSel, spareSize, spareOnly, column, expAddr, expLen}
  localparam int NV = 17;
  localparam logic [49:0] VEC [NV] = '{
    {2'd0, 8'd16,  1'b0, 13'd0,    13'h0000, 13'd512},  // R3 first main byte
    {2'd0, 8'd16,  1'b0, 13'd511,  13'h01FF, 13'd1},    // R3 last main byte
    {2'd0, 8'd16,  1'b0, 13'd512,  13'h1000, 13'd16},   // R4 boundary to spare 0
    {2'd0, 8'd16,  1'b0, 13'd520,  13'h1008, 13'd8},    // R7 single window
    {2'd1, 8'd64,  1'b0, 13'd1000, 13'h03E8, 13'd1048}, // R3 mid main
    {2'd1, 8'd64,  1'b0, 13'd2048, 13'h1000, 13'd16},   // R4 boundary
    {2'd1, 8'd64,  1'b0, 13'd2065, 13'h1041, 13'd15},   // R8 window 1
    {2'd1, 8'd64,  1'b0, 13'd2111, 13'h10CF, 13'd1},    // R7 last of 4
    {2'd2, 8'd128, 1'b0, 13'd4223, 13'h11CF, 13'd1},    // R6 window 7
    {2'd2, 8'd218, 1'b1, 13'd181,  13'h1199, 13'd1},    // R6 odd split window 6
    {2'd2, 8'd218, 1'b1, 13'd182,  13'h11C0, 13'd36},   // R7 remainder start
    {2'd2, 8'd218, 1'b0, 13'd4313, 13'h11E3, 13'd1},    // R7 last spare byte
    {2'd2, 8'd218, 1'b0, 13'd4095, 13'h0FFF, 13'd1},    // R3 last main byte
    {2'd1, 8'd64,  1'b1, 13'd5,    13'h1005, 13'd11},   // R5 spare-only
    {2'd2, 8'd218, 1'b0, 13'd4314, 13'h11E4, 13'd0},    // R9 past spare end
    {2'd0, 8'd16,  1'b1, 13'd0,    13'h1000, 13'd16},   // R5 spare-only origin
    {2'd3, 8'd128, 1'b0, 13'd4096, 13'h1000, 13'd16}    // R3 select 3 as 4096
  };
  string tagOf [NV] = '{"R3","R3","R4","R7","R3","R4","R8","R7","R6","R6","R7","R7","R3","R5","R9","R5","R3"};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [49:0] v);
    pageSel   = v[49:48];
    spareSize = v[47:40];
    spareOnly = v[39];
    column    = v[38:26];
    reqValid  = 1'b1;
  endtask

  task automatic judge(input string tag, input logic [49:0] v);
    chk(tag, 32'(respValid), 32'd1, "respValid");
    chk(tag, 32'(bufAddr), 32'(v[25:13]), "bufAddr");
    chk(tag, 32'(runLen), 32'(v[12:0]), "runLen");
    chk(tag, 32'(inSpare), 32'(v[25:13] >= 13'h1000), "inSpare");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", 32'(respValid), 0, "respValid in reset");
    chk("R1", 32'(bufAddr), 0, "bufAddr in reset");
    chk("R1", 32'(runLen), 0, "runLen in reset");
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", 32'(inSpare), 0, "inSpare after reset");
    chk("R1", 32'(respValid), 0, "respValid after reset");

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      reqValid = 1'b0;
      judge(tagOf[i], VEC[i]);
    end

    // R2: idle cycle with changed inputs leaves outputs untouched
    column = 13'd7; pageSel = 2'd0; spareOnly = 1'b1;
    @(negedge clk);
    chk("R2", 32'(respValid), 0, "respValid idle");
    chk("R2", 32'(bufAddr), 32'(VEC[NV-1][25:13]), "bufAddr held");
    chk("R2", 32'(runLen), 32'(VEC[NV-1][12:0]), "runLen held");

    // R2: back-to-back requests, each result one cycle later
    drive(VEC[6]);
    @(negedge clk);
    judge("R2", VEC[6]);
    drive(VEC[10]);
    @(negedge clk);
    reqValid = 1'b0;
    judge("R2", VEC[10]);
    @(negedge clk);
    chk("R2", 32'(respValid), 0, "respValid drops");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule